// File: doc/BRIEF.md
# Programmable FFT Stage and Step Sequencer

This block walks a radix-2 decimation-in-frequency transform through its stages and, within each stage, through its butterflies. The transform length is chosen at run time from five sizes (64 to 1024 points) by a 3-bit length code. The code is captured when a start pulse is accepted and stays fixed until the transform ends.

The block issues one butterfly index per clock cycle. The stage index does not begin at zero. It begins at a preset that depends on the length and always finishes at stage 9. The butterfly (step) index is a 9-bit count whose upper bits are held at zero for the shorter lengths. Because of this, one address map built for 1024 points serves every length. Downstream address, twiddle and arithmetic logic consume the stage and step values whenever the valid strobe is high.

A single-cycle done pulse follows the last butterfly of stage 9, and the block goes idle again.

Top module: `fft_pass_sequencer`

## Requirements
- R1: While reset is asserted and after its release, `step_valid` and `done` are 0, and `stage` and `step` are 0.
- R2: A `start` seen while idle is accepted. In the next cycle `step_valid` is 1, `step` is 0, and `stage` holds the preset for the length code. The presets are: code 3'b000 (64 points) gives 4, 3'b001 (128) gives 3, 3'b010 (256) gives 2, 3'b011 (512) gives 1, and 3'b111 (1024) gives 0.
- R3: While `step_valid` is 1, `step` rises by one every cycle from 0 up to N/2-1. That last value is 31, 63, 127, 255 or 511, which means step bits 8 down to 5 are forced to 0 as the length requires.
- R4: In the cycle after the last step of a stage below 9, `stage` is one higher and `step` is 0, with no idle cycle between the two stages.
- R5: In the cycle after the last step of stage 9, `step_valid` is 0 and `done` is 1 for exactly one cycle. A transform therefore lasts (N/2)*log2(N) valid cycles.
- R6: The length code is sampled only when `start` is accepted. Changing `len_code` during a transform has no effect on that transform.
- R7: A `start` while a transform is running is ignored. The stage and step sequence continues unchanged.
- R8: The unlisted codes 3'b100, 3'b101 and 3'b110 select the 1024-point sequence (preset 0, last step 511).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| start | input | 1 | Start request, accepted only while idle |
| len_code | input | 3 | Transform length select |
| stage | output | STAGE_W (4) | Current stage index |
| step | output | STEP_W (9) | Current butterfly index within the stage |
| step_valid | output | 1 | High for each cycle that carries a butterfly |
| done | output | 1 | One-cycle pulse after the final butterfly |

## Verification
The bench uses the default build (MAX_LOG = 10, a 9-bit step and a 4-bit stage). With this build all eight length codes can be run back to back within a few tens of thousands of cycles. Every issued (stage, step) pair is compared against a count derived from N. Because the whole sweep fits, the last step of every stage and the handover into done are checked for each length, including the unlisted codes. Some runs change the length code and pulse start in the middle of a transform, to show that both are ignored.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    LEN_64   = 3'b000,
    LEN_128  = 3'b001,
    LEN_256  = 3'b010,
    LEN_512  = 3'b011,
    LEN_1024 = 3'b111
  } len_code_e;

  // Number of stages skipped below the largest size; unlisted codes act as the largest.
  function automatic logic [2:0] stage_skip(input logic [CODE_W-1:0] code);
    logic [2:0] r;
    case (code)
      LEN_64:  r = 3'd4;
      LEN_128: r = 3'd3;
      LEN_256: r = 3'd2;
      LEN_512: r = 3'd1;
      default: r = 3'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/seqr_len_decode.sv
module seqr_len_decode
  import seqr_pkg::*;
#(
  parameter int STAGE_W = 4,
  parameter int STEP_W  = 9
) (
  input  logic [CODE_W-1:0]  code,
  output logic [STAGE_W-1:0] stage_preset,
  output logic [STEP_W-1:0]  step_mask
);

  logic [2:0] skip;

  always_comb begin
    skip         = stage_skip(code);
    stage_preset = STAGE_W'(skip);
  end

  // Bit i of the step survives only below STEP_W - skip.
  for (genvar i = 0; i < STEP_W; i++) begin : g_mask
    assign step_mask[i] = (i < (STEP_W - int'(skip)));
  end

endmodule

// File: rtl/seqr_step_ctr.sv
module seqr_step_ctr #(
  parameter int STEP_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [STEP_W-1:0] mask,
  output logic [STEP_W-1:0] step,
  output logic              wrap
);

  logic [STEP_W-1:0] step_q, step_d;
  logic              step_ce;

  always_comb begin
    step_ce = clr | en;
    step_d  = clr ? '0 : ((step_q + STEP_W'(1)) & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_ce) step_q <= step_d;
  end

  assign step = step_q;
  assign wrap = (step_q == mask);

endmodule

// File: rtl/seqr_stage_ctr.sv
module seqr_stage_ctr #(
  parameter int STAGE_W = 4,
  parameter int LAST    = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               inc,
  input  logic [STAGE_W-1:0] preset,
  output logic [STAGE_W-1:0] stage,
  output logic               at_last
);

  logic [STAGE_W-1:0] stage_q, stage_d;
  logic               stage_ce;

  always_comb begin
    stage_ce = load | inc;
    stage_d  = load ? preset : (stage_q + STAGE_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_ce) stage_q <= stage_d;
  end

  assign stage   = stage_q;
  assign at_last = (stage_q == STAGE_W'(LAST));

endmodule

// File: rtl/fft_pass_sequencer.sv
module fft_pass_sequencer
  import seqr_pkg::*;
#(
  parameter int MAX_LOG = 10,
  localparam int STAGE_W = $clog2(MAX_LOG),
  localparam int STEP_W  = MAX_LOG - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2:0]         len_code,
  output logic [STAGE_W-1:0] stage,
  output logic [STEP_W-1:0]  step,
  output logic               step_valid,
  output logic               done
);

  localparam int LAST_STAGE = MAX_LOG - 1;

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_sel;
  logic              accept, finish, stage_inc;
  logic [STAGE_W-1:0] preset;
  logic [STEP_W-1:0]  mask;
  logic               wrap, at_last;

  always_comb begin
    accept    = start & ~busy_q;
    code_sel  = accept ? len_code : code_q;
    finish    = busy_q & wrap & at_last;
    stage_inc = busy_q & wrap & ~at_last;
    busy_d    = accept | (busy_q & ~finish);
    done_d    = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (accept) code_q <= len_code;
  end

  seqr_len_decode #(.STAGE_W(STAGE_W), .STEP_W(STEP_W)) u_dec (
    .code         (code_sel),
    .stage_preset (preset),
    .step_mask    (mask)
  );

  seqr_step_ctr #(.STEP_W(STEP_W)) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (busy_q),
    .mask  (mask),
    .step  (step),
    .wrap  (wrap)
  );

  seqr_stage_ctr #(.STAGE_W(STAGE_W), .LAST(LAST_STAGE)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .inc     (stage_inc),
    .preset  (preset),
    .stage   (stage),
    .at_last (at_last)
  );

  assign step_valid = busy_q;
  assign done       = done_q;

endmodule

// File: rtl/seqr_checker.sv
module seqr_checker #(
  parameter int STAGE_W = 4,
  parameter int STEP_W  = 9,
  parameter int LAST    = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [2:0]         len_code,
  input logic [2:0]         code_q,
  input logic [STAGE_W-1:0] stage,
  input logic [STEP_W-1:0]  step,
  input logic               step_valid,
  input logic               done
);

  function automatic int lg_of(input logic [2:0] c);
    case (c)
      3'b000:  return 6;
      3'b001:  return 7;
      3'b010:  return 8;
      3'b011:  return 9;
      default: return 10;
    endcase
  endfunction

  int end_step;
  int first_stage;
  always_comb begin
    end_step    = (1 << (lg_of(code_q) - 1)) - 1;
    first_stage = 10 - lg_of(len_code);
  end

  a_r2_start_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_valid && start) |=> (step_valid && step == '0 && int'(stage) == $past(first_stage)));

  a_r3_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> (int'(step) <= end_step));

  a_r3_step_incr: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && int'(step) != end_step) |=>
      (step_valid && step == $past(step) + 1'b1 && $stable(stage)));

  a_r4_stage_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && int'(step) == end_step && int'(stage) != LAST) |=>
      (step_valid && step == '0 && stage == $past(stage) + 1'b1));

  a_r5_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && int'(step) == end_step && int'(stage) == LAST) |=> (done && !step_valid));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid ##1 step_valid) |-> $stable(code_q));

endmodule

bind fft_pass_sequencer seqr_checker #(
  .STAGE_W (STAGE_W),
  .STEP_W  (STEP_W),
  .LAST    (MAX_LOG - 1)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .len_code   (len_code),
  .code_q     (code_q),
  .stage      (stage),
  .step       (step),
  .step_valid (step_valid),
  .done       (done)
);

// File: tb/sim_fft_pass_sequencer.sv
module sim_fft_pass_sequencer;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [2:0] len_code;
  logic [3:0] stage;
  logic [8:0] step;
  logic       step_valid;
  logic       done;

  int vectors;
  int miscompares;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  fft_pass_sequencer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .len_code   (len_code),
    .stage      (stage),
    .step       (step),
    .step_valid (step_valid),
    .done       (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lg_of(input logic [2:0] c);
    case (c)
      3'b000:  return 6;
      3'b001:  return 7;
      3'b010:  return 8;
      3'b011:  return 9;
      default: return 10;
    endcase
  endfunction

  task automatic run_one(input logic [2:0] code, input bit perturb);
    int lg   = lg_of(code);
    int pre  = 10 - lg;
    int last = (1 << (lg - 1)) - 1;
    @(negedge clk);
    start    = 1'b1;
    len_code = code;
    @(negedge clk);
    start = 1'b0;
    chk("R2 preset stage", int'(stage), pre);
    for (int s = pre; s <= 9; s++) begin
      for (int k = 0; k <= last; k++) begin
        chk("R3 step", int'(step), k);
        chk("R4 stage", int'(stage), s);
        chk("R5 valid high", int'(step_valid), 1);
        chk("R5 done low", int'(done), 0);
        if (perturb && s == pre && k == 2) begin
          start    = 1'b1;     // R7 start while busy
          len_code = ~code;    // R6 code change mid-run
        end
        if (perturb && s == pre && k == 3) start = 1'b0;
        @(negedge clk);
      end
    end
    chk("R5 valid low after end", int'(step_valid), 0);
    chk("R5 done pulse", int'(done), 1);
    @(negedge clk);
    chk("R5 done single cycle", int'(done), 0);
    chk("R7 stays idle", int'(step_valid), 0);
  endtask

  initial begin
    vectors     = 0;
    miscompares = 0;
    rst_n    = 1'b0;
    start    = 1'b0;
    len_code = 3'b000;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(step_valid), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset stage", int'(stage), 0);
    chk("R1 reset step", int'(step), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", int'(step_valid), 0);
    for (int c = 0; c < 8; c++) begin
      run_one(3'(c), 1'b0);                 // R8 covers codes 4..6
    end
    run_one(3'b000, 1'b1);
    run_one(3'b011, 1'b1);
    run_one(3'b111, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule